// File: doc/BRIEF.md
# General-Purpose Register File with Link Target

This block is the integer register store for a single-cycle 32-bit processor. It keeps thirty-two 32-bit words, addressed by 5-bit indices. Two read ports return operands combinationally, and one write port loads a result into the selected word on the rising clock edge. The write index passes through an enabled one-hot decoder, so at most one word loads per cycle. Each read port picks its word through a full-width selector driven by its index.

Index 0 is a constant zero slot. It has no storage, any read of it returns zero, and a write aimed at it changes nothing. Index 31 is an ordinary word that also serves as the implicit destination for subroutine-call style instructions. The `link_req` input forces a write to index 31 in that cycle, whatever `dst_idx` and `dst_we` say. A synchronous reset clears every word.

All ports are plain control and data pins with no handshake. A read result is valid whenever its index is stable. A write is accepted on every rising edge at which it is requested, so there is never any back-pressure.

Top module: `gpr_file`

## Requirements
- R1: A rising edge with `rst` high clears every register, so afterwards all 32 indices read 0 on both ports.
- R2: A rising edge with `dst_we`=1, `link_req`=0 and `dst_idx` in 1..31 stores `dst_val` into register `dst_idx`. Reads of that index return it from the next cycle on.
- R3: A rising edge with `dst_we`=0 and `link_req`=0 leaves every register unchanged.
- R4: Index 0 always reads 0 on both ports. A write with `dst_idx`=0 (and `link_req`=0) changes no register.
- R5: The two read ports are independent. Both may address the same register in the same cycle and both return its value.
- R6: Reads are combinational and have no bypass. While a write to index k is pending before its edge, reading k returns the value held before that edge.
- R7: With `link_req`=1, the rising edge stores `dst_val` into register 31, ignoring `dst_idx` and `dst_we`. No other register changes.
- R8: At any edge at most one register loads, and it is exactly one whenever a write (through `dst_we` or `link_req`) is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes happen on the rising edge |
| rst | input | 1 | Synchronous active-high clear of all registers |
| src_a_idx | input | 5 | Index for read port A |
| src_a_val | output | 32 | Value of the register at `src_a_idx` |
| src_b_idx | input | 5 | Index for read port B |
| src_b_val | output | 32 | Value of the register at `src_b_idx` |
| dst_we | input | 1 | Write request for `dst_idx` |
| dst_idx | input | 5 | Destination index of the write |
| dst_val | input | 32 | Data to store |
| link_req | input | 1 | Force a write of `dst_val` into register 31 |

## Verification
Read results are due in the same cycle that the index is applied. The bench changes inputs on the falling clock edge and samples both read ports 1 ns later, well before the next rising edge. A write becomes visible only after the following rising edge. The bench therefore checks the old value just before that edge (no bypass), updates its reference array at the edge, and reads the new contents back in the following low phases, sweeping all 32 indices after each class of stimulus.

// File: rtl/gpr_pkg.sv
`timescale 1ns/1ps
package gpr_pkg;
  parameter int unsigned GPR_COUNT = 32;
  parameter int unsigned GPR_WIDTH = 32;
endpackage

// File: rtl/gpr_wr_decode.sv
`timescale 1ns/1ps
module gpr_wr_decode #(
  parameter int unsigned NREG = gpr_pkg::GPR_COUNT,
  localparam int unsigned AW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [AW-1:0]   idx,
  output logic [NREG-1:0] sel
);
  for (genvar i = 0; i < NREG; i++) begin : g_line
    assign sel[i] = en && (idx == AW'(i));
  end

  a_r8_at_most_one: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel));
  a_r8_one_when_enabled: assert property (@(posedge clk) disable iff (rst)
    en |-> ($countones(sel) == 1));
  a_r3_idle_none: assert property (@(posedge clk) disable iff (rst)
    !en |-> (sel == '0));
endmodule

// File: rtl/gpr_word.sv
`timescale 1ns/1ps
module gpr_word #(
  parameter int unsigned DW = gpr_pkg::GPR_WIDTH
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> (q == $past(q)));
  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    load |=> (q == $past(d)));
endmodule

// File: rtl/gpr_rd_select.sv
`timescale 1ns/1ps
module gpr_rd_select #(
  parameter int unsigned NREG = gpr_pkg::GPR_COUNT,
  parameter int unsigned DW   = gpr_pkg::GPR_WIDTH,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic [NREG-1:0][DW-1:0] words,
  input  logic [AW-1:0]           idx,
  output logic [DW-1:0]           val
);
  always_comb begin
    val = '0;
    for (int i = 0; i < NREG; i++) begin
      if (idx == AW'(i)) val = words[i];
    end
  end
endmodule

// File: rtl/gpr_file.sv
`timescale 1ns/1ps
module gpr_file #(
  parameter int unsigned NREG = gpr_pkg::GPR_COUNT,
  parameter int unsigned DW   = gpr_pkg::GPR_WIDTH,
  localparam int unsigned AW  = $clog2(NREG),
  localparam logic [AW-1:0] LINK_IDX = AW'(NREG - 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] src_a_idx,
  output logic [DW-1:0] src_a_val,
  input  logic [AW-1:0] src_b_idx,
  output logic [DW-1:0] src_b_val,
  input  logic          dst_we,
  input  logic [AW-1:0] dst_idx,
  input  logic [DW-1:0] dst_val,
  input  logic          link_req
);
  logic                  wr_go;
  logic [AW-1:0]         wr_idx;
  logic [NREG-1:0]       wr_sel;
  logic [NREG-1:0][DW-1:0] words;

  // Link request overrides both the index and the enable.
  assign wr_go  = dst_we | link_req;
  assign wr_idx = link_req ? LINK_IDX : dst_idx;

  gpr_wr_decode #(.NREG(NREG)) u_dec (
    .clk (clk),
    .rst (rst),
    .en  (wr_go),
    .idx (wr_idx),
    .sel (wr_sel)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    if (i == 0) begin : g_zero
      assign words[i] = '0;
    end else begin : g_store
      gpr_word #(.DW(DW)) u_word (
        .clk  (clk),
        .rst  (rst),
        .load (wr_sel[i]),
        .d    (dst_val),
        .q    (words[i])
      );
    end
  end

  gpr_rd_select #(.NREG(NREG), .DW(DW)) u_rd_a (
    .words (words),
    .idx   (src_a_idx),
    .val   (src_a_val)
  );

  gpr_rd_select #(.NREG(NREG), .DW(DW)) u_rd_b (
    .words (words),
    .idx   (src_b_idx),
    .val   (src_b_val)
  );

  a_r4_zero_a: assert property (@(posedge clk) disable iff (rst)
    (src_a_idx == '0) |-> (src_a_val == '0));
  a_r4_zero_b: assert property (@(posedge clk) disable iff (rst)
    (src_b_idx == '0) |-> (src_b_val == '0));
  a_r4_zero_write: assert property (@(posedge clk) disable iff (rst)
    wr_sel[0] |=> (words == $past(words)));
  a_r7_link_a: assert property (@(posedge clk) disable iff (rst)
    link_req |=> ((src_a_idx != LINK_IDX) || (src_a_val == $past(dst_val))));
  a_r5_same_index: assert property (@(posedge clk) disable iff (rst)
    (src_a_idx == src_b_idx) |-> (src_a_val == src_b_val));
  a_r2_write_a: assert property (@(posedge clk) disable iff (rst)
    (dst_we && !link_req && dst_idx != '0) |=>
      ((src_a_idx != $past(dst_idx)) || (src_a_val == $past(dst_val))));
endmodule

// File: tb/tb_gpr_file.sv
`timescale 1ns/1ps
module tb_gpr_file;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  src_a_idx = '0;
  logic [31:0] src_a_val;
  logic [4:0]  src_b_idx = '0;
  logic [31:0] src_b_val;
  logic        dst_we = 1'b0;
  logic [4:0]  dst_idx = '0;
  logic [31:0] dst_val = '0;
  logic        link_req = 1'b0;

  logic [31:0] model [32];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpr_file dut (
    .clk(clk), .rst(rst),
    .src_a_idx(src_a_idx), .src_a_val(src_a_val),
    .src_b_idx(src_b_idx), .src_b_val(src_b_val),
    .dst_we(dst_we), .dst_idx(dst_idx), .dst_val(dst_val),
    .link_req(link_req)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < 32; i++) model[i] = '0;
  endtask

  // Sweep all indices: port A ascending, port B descending.
  task automatic read_all(input string req);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      dst_we = 1'b0; link_req = 1'b0;
      src_a_idx = 5'(i); src_b_idx = 5'(31 - i);
      #1;
      check(req, src_a_val, model[i]);
      check(req, src_b_val, model[31 - i]);
    end
  endtask

  // One write cycle; checks the pre-edge value on port A (R6).
  task automatic do_write(input logic we, input logic [4:0] idx,
                          input logic [31:0] val, input logic lnk);
    logic [4:0] tgt;
    @(negedge clk);
    dst_we = we; dst_idx = idx; dst_val = val; link_req = lnk;
    tgt = lnk ? 5'd31 : idx;
    src_a_idx = tgt;
    #1;
    check("R6", src_a_val, model[tgt]);
    @(posedge clk);
    if ((we || lnk) && tgt != 5'd0) model[tgt] = val;
    @(negedge clk);
    dst_we = 1'b0; link_req = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    clear_model();
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    read_all("R1");

    // R2: load every writable index with a distinct pattern
    for (int i = 1; i < 32; i++)
      do_write(1'b1, 5'(i), 32'hA5000000 ^ (32'(i) * 32'h01010101) ^ 32'(i), 1'b0);
    read_all("R2");

    // R3: disabled writes change nothing
    for (int i = 0; i < 32; i++)
      do_write(1'b0, 5'(i), 32'hDEAD0000 | 32'(i), 1'b0);
    read_all("R3");

    // R4: writes to index 0 are discarded
    do_write(1'b1, 5'd0, 32'hFFFFFFFF, 1'b0);
    do_write(1'b1, 5'd0, 32'h12345678, 1'b0);
    read_all("R4");

    // R5: both ports on the same register
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      src_a_idx = 5'(i); src_b_idx = 5'(i);
      #1;
      check("R5", src_a_val, model[i]);
      check("R5", src_b_val, model[i]);
    end

    // R7: link writes ignore dst_idx and dst_we
    do_write(1'b0, 5'd3, 32'h0BADF00D, 1'b1);
    do_write(1'b1, 5'd0, 32'h600DCAFE, 1'b1);
    do_write(1'b1, 5'd17, 32'h13579BDF, 1'b1);
    read_all("R7");

    // R8: successive writes to neighbours each land in one slot only
    for (int i = 1; i < 32; i++)
      do_write(1'b1, 5'(i), ~(32'(i) << 3), 1'b0);
    read_all("R8");

    // R1: reset again from a full file
    @(negedge clk); rst = 1'b1;
    @(posedge clk);
    @(negedge clk); rst = 1'b0;
    clear_model();
    read_all("R1");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule